// File: doc/BRIEF.md
# Transmit Training Scheduler and Fault Injector

This block sits on the transmit side of a 16-lane source-synchronous packet interface, between the packet scheduler and the output stage. It forwards upstream words and their control flag unchanged. At programmed intervals it replaces them with a training burst that lets the far end re-align its lanes. While a burst is running it raises `busy`, so that upstream holds its traffic. A configurable repeat count sets the length of each burst. A force bit keeps training running without a break.

For diagnostics, a one-shot command corrupts the DIP-4 parity of a chosen number of upstream control words. The command clears itself once that number has been reached. Data lane 0 can also be skewed against the other fifteen lanes by up to three bit times, which exercises the receiver's deskew logic. The block neither computes DIP-4 nor drives the serializer.

Top module: `txtrain_top`

## Requirements
- R1: While `rst` is high, `out_data`, `out_ctl`, `busy` and `err_pend` are all 0 from the next clock edge on.
- R2: An interval counter restarts at 0 at reset and at the end of every training insertion. It advances once per cycle outside training. Training starts on the first edge at which the counter is at least `cfg_interval` and `in_gap` is 1. Training never starts while `in_gap` is 0.
- R3: Each insertion holds `cfg_alpha`+1 repetitions. A repetition is 10 words of 16'h0FFF with `out_ctl`=1 followed by 10 words of 16'hF000 with `out_ctl`=0. `busy` stays high for exactly 20×(`cfg_alpha`+1) cycles.
- R4: While `cfg_force` is 1, training begins at the next gap and then repeats without a break. After `cfg_force` clears, training ends at the next repetition boundary once at least `cfg_alpha`+1 repetitions have run.
- R5: Outside training, `out_data` and `out_ctl` equal `in_data` and `in_ctl` one cycle later. The exceptions are the corruption in R6 and the skew in R8. Upstream words presented while `busy` is 1 are dropped.
- R6: A `cmd_err_ins` pulse with `cfg_dip_num`=N>0 sets `err_pend`. Bit 0 of each of the next N upstream control words is then inverted. That bit is the lowest bit of the DIP-4 nibble held in bits [3:0]. Upstream data words are never altered.
- R7: `err_pend` clears on its own after the Nth corrupted control word. A pulse with `cfg_dip_num`=0 clears `err_pend` at once and corrupts nothing.
- R8: Bit 0 of `out_data` is delayed by `cfg_bit_delay` (0 to 3) further cycles relative to bits [15:1]. Bits [15:1] always have a latency of one cycle.
- R9: Training words are never corrupted by a pending error insertion, and they do not use up its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Upstream word |
| in_ctl | input | 1 | Upstream word is a control word |
| in_gap | input | 1 | Upstream is between bursts; training may start |
| cfg_interval | input | 16 | Minimum cycles between training insertions |
| cfg_alpha | input | 8 | Training repetitions minus one |
| cfg_force | input | 1 | Train continuously |
| cfg_dip_num | input | 4 | Number of DIP-4 nibbles to corrupt |
| cmd_err_ins | input | 1 | One-cycle pulse that arms error insertion |
| cfg_bit_delay | input | 2 | Extra delay of lane 0 in cycles |
| out_data | output | 16 | Word sent to the output stage |
| out_ctl | output | 1 | Output word is a control word |
| busy | output | 1 | Training in progress; upstream must hold |
| err_pend | output | 1 | Self-clearing error-insert command bit |

## Verification
Every output of this block is registered, so the data path has a latency of one clock. A word presented before edge k shows up after edge k with its corruption and its training substitution already applied. Lane 0 appears 1+`cfg_bit_delay` edges after the word that carried it. `busy` and `err_pend` change on the same edge that consumes the deciding input: the gap word that starts training, or the Nth control word that finishes insertion. The bench drives every input on the falling edge and advances a reference model by one rising edge. It then compares all outputs on the following falling edge, which is the exact cycle in which the RTL updates.

// File: rtl/txtrain_pkg.sv
package txtrain_pkg;

  typedef enum logic {
    ST_PASS  = 1'b0,
    ST_TRAIN = 1'b1
  } tr_state_e;

endpackage

// File: rtl/train_sched.sv
module train_sched
  import txtrain_pkg::*;
#(
  parameter int INT_W     = 16,
  parameter int ALPHA_W   = 8,
  parameter int TRAIN_LEN = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_gap,
  input  logic [INT_W-1:0]   cfg_interval,
  input  logic [ALPHA_W-1:0] cfg_alpha,
  input  logic               cfg_force,
  output logic               training,
  output logic               ctl_phase
);

  localparam int PH_LAST = 2 * TRAIN_LEN - 1;
  localparam int PH_W    = $clog2(PH_LAST + 1);

  tr_state_e          state;
  logic [PH_W-1:0]    phase;
  logic [ALPHA_W-1:0] rep;
  logic [INT_W-1:0]   cnt;
  logic               start;
  logic               rep_end;

  assign start     = (state == ST_PASS) && in_gap && (cfg_force || (cnt >= cfg_interval));
  assign rep_end   = (phase == PH_W'(PH_LAST));
  assign training  = (state == ST_TRAIN);
  assign ctl_phase = (phase < PH_W'(TRAIN_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_PASS;
      phase <= '0;
      rep   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        ST_PASS: begin
          if (start) begin
            state <= ST_TRAIN;
            phase <= '0;
            rep   <= '0;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (rep_end) begin
            if ((rep >= cfg_alpha) && !cfg_force) begin
              state <= ST_PASS;
              cnt   <= '0;
            end else begin
              phase <= '0;
              if (rep < cfg_alpha) rep <= rep + 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
      endcase
    end
  end

  // R2
  gap_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(training) |-> $past(in_gap));

  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(training) |-> (cnt == '0));

  // R3
  end_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(training) |-> ($past(phase) == PH_W'(PH_LAST)));

endmodule

// File: rtl/dip_err_inj.sv
module dip_err_inj #(
  parameter int NUM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic [NUM_W-1:0] cfg_num,
  input  logic             word_is_ctl,
  output logic             flip,
  output logic             pend
);

  logic [NUM_W-1:0] rem;

  assign flip = pend && word_is_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      rem  <= '0;
    end else if (cmd) begin
      pend <= (cfg_num != '0);
      rem  <= cfg_num;
    end else if (flip) begin
      rem <= rem - 1'b1;
      if (rem == NUM_W'(1)) pend <= 1'b0;
    end
  end

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> ($past(cmd) || $past(rem) == NUM_W'(1)));

  // R6
  pend_count_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> (rem != '0));

endmodule

// File: rtl/lane_skew.sv
module lane_skew #(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_bit,
  input  logic [DLY_W-1:0] dly,
  output logic             out_bit
);

  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [DEPTH-1:0] sr;
  logic [DEPTH:0]   tap;

  assign tap[0] = in_bit;

  genvar gi;
  generate
    for (gi = 1; gi <= DEPTH; gi++) begin : g_tap
      assign tap[gi] = sr[gi-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      out_bit <= 1'b0;
    end else begin
      sr      <= {sr[DEPTH-2:0], in_bit};
      out_bit <= tap[dly];
    end
  end

  // R8
  zero_skew_chk: assert property (@(posedge clk) disable iff (rst)
    (dly == '0) |=> (out_bit == $past(in_bit)));

endmodule

// File: rtl/txtrain_top.sv
module txtrain_top #(
  parameter int              LANES     = 16,
  parameter int              INT_W     = 16,
  parameter int              ALPHA_W   = 8,
  parameter int              NUM_W     = 4,
  parameter int              DLY_W     = 2,
  parameter int              TRAIN_LEN = 10,
  parameter logic [LANES-1:0] CTL_WORD = 16'h0FFF,
  parameter logic [LANES-1:0] DAT_WORD = 16'hF000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES-1:0]   in_data,
  input  logic               in_ctl,
  input  logic               in_gap,
  input  logic [INT_W-1:0]   cfg_interval,
  input  logic [ALPHA_W-1:0] cfg_alpha,
  input  logic               cfg_force,
  input  logic [NUM_W-1:0]   cfg_dip_num,
  input  logic               cmd_err_ins,
  input  logic [DLY_W-1:0]   cfg_bit_delay,
  output logic [LANES-1:0]   out_data,
  output logic               out_ctl,
  output logic               busy,
  output logic               err_pend
);

  logic             training;
  logic             ctl_phase;
  logic             flip;
  logic             pass_ctl;
  logic [LANES-1:0] mux_word;
  logic             mux_ctl;
  logic [LANES-1:1] hi_q;
  logic             lane0_q;

  train_sched #(
    .INT_W    (INT_W),
    .ALPHA_W  (ALPHA_W),
    .TRAIN_LEN(TRAIN_LEN)
  ) u_sched (
    .clk         (clk),
    .rst         (rst),
    .in_gap      (in_gap),
    .cfg_interval(cfg_interval),
    .cfg_alpha   (cfg_alpha),
    .cfg_force   (cfg_force),
    .training    (training),
    .ctl_phase   (ctl_phase)
  );

  assign pass_ctl = !training && in_ctl;

  dip_err_inj #(
    .NUM_W(NUM_W)
  ) u_inj (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd_err_ins),
    .cfg_num    (cfg_dip_num),
    .word_is_ctl(pass_ctl),
    .flip       (flip),
    .pend       (err_pend)
  );

  always_comb begin
    if (training) begin
      mux_ctl  = ctl_phase;
      mux_word = ctl_phase ? CTL_WORD : DAT_WORD;
    end else begin
      mux_ctl  = in_ctl;
      mux_word = in_data ^ {{(LANES-1){1'b0}}, flip};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      out_ctl <= 1'b0;
    end else begin
      hi_q    <= mux_word[LANES-1:1];
      out_ctl <= mux_ctl;
    end
  end

  lane_skew #(
    .DLY_W(DLY_W)
  ) u_skew (
    .clk    (clk),
    .rst    (rst),
    .in_bit (mux_word[0]),
    .dly    (cfg_bit_delay),
    .out_bit(lane0_q)
  );

  assign out_data = {hi_q, lane0_q};
  assign busy     = training;

  // R5
  pass_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (out_ctl == $past(in_ctl)));

  // R3
  train_word_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (out_data[LANES-1:1] == (out_ctl ? CTL_WORD[LANES-1:1] : DAT_WORD[LANES-1:1])));

  // R9
  no_train_flip_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !flip);

endmodule

// File: tb/txtrain_top_bench.sv
module txtrain_top_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_data = '0;
  logic        in_ctl = 1'b0;
  logic        in_gap = 1'b0;
  logic [15:0] cfg_interval = 16'hFFFF;
  logic [7:0]  cfg_alpha = '0;
  logic        cfg_force = 1'b0;
  logic [3:0]  cfg_dip_num = '0;
  logic        cmd_err_ins = 1'b0;
  logic [1:0]  cfg_bit_delay = '0;
  logic [15:0] out_data;
  logic        out_ctl, busy, err_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  txtrain_top u_txtrain_top (
    .clk(clk), .rst(rst), .in_data(in_data), .in_ctl(in_ctl), .in_gap(in_gap),
    .cfg_interval(cfg_interval), .cfg_alpha(cfg_alpha), .cfg_force(cfg_force),
    .cfg_dip_num(cfg_dip_num), .cmd_err_ins(cmd_err_ins), .cfg_bit_delay(cfg_bit_delay),
    .out_data(out_data), .out_ctl(out_ctl), .busy(busy), .err_pend(err_pend)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  bit        m_tr, m_pend;
  int        m_ph, m_rep, m_cnt, m_rem;
  bit [2:0]  m_sr;
  bit [15:0] e_data;
  bit        e_ctl;
  int        flips_seen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, advance one rising edge, compare at next falling edge
  task automatic step();
    bit [15:0] w;
    bit c, hit, start;
    if (rst) begin
      m_tr = 0; m_pend = 0; m_ph = 0; m_rep = 0; m_cnt = 0; m_rem = 0; m_sr = 0;
      e_data = 0; e_ctl = 0;
    end else begin
      start = !m_tr && in_gap && (cfg_force || m_cnt >= int'(cfg_interval));
      if (m_tr) begin
        c = (m_ph < 10);
        w = c ? 16'h0FFF : 16'hF000;
      end else begin
        c = in_ctl;
        w = in_data;
        if (m_pend && in_ctl) w[0] = ~w[0];
      end
      hit = !m_tr && in_ctl && m_pend;
      e_ctl = c;
      e_data[15:1] = w[15:1];
      e_data[0] = (cfg_bit_delay == 0) ? w[0] : m_sr[int'(cfg_bit_delay) - 1];
      m_sr = {m_sr[1:0], w[0]};
      if (!m_tr) begin
        if (start) begin m_tr = 1; m_ph = 0; m_rep = 0; end
        else if (m_cnt != 16'hFFFF) m_cnt++;
      end else if (m_ph == 19) begin
        if (m_rep >= int'(cfg_alpha) && !cfg_force) begin m_tr = 0; m_cnt = 0; end
        else begin m_ph = 0; if (m_rep < int'(cfg_alpha)) m_rep++; end
      end else m_ph++;
      if (cmd_err_ins) begin
        if (cfg_dip_num == 0) m_pend = 0;
        else begin m_pend = 1; m_rem = int'(cfg_dip_num); end
      end else if (hit) begin
        m_rem--;
        if (m_rem == 0) m_pend = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(busy == m_tr, "R2 R3 R4 busy", busy, m_tr);
    chk(out_ctl == e_ctl && out_data[15:1] == e_data[15:1], "R5 R9 word", {out_ctl, out_data}, {e_ctl, e_data});
    chk(out_data[0] == e_data[0], "R8 lane0", out_data[0], e_data[0]);
    chk(err_pend == m_pend, "R6 R7 pend", err_pend, m_pend);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    if (!done) $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    int k, cnt, prev_in0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1 reset state
    rst = 1;
    in_data = 16'hFFFF; in_ctl = 1; in_gap = 1;
    repeat (4) step();
    chk(out_data == 0 && out_ctl == 0 && busy == 0 && err_pend == 0, "R1", {out_ctl, busy, err_pend, out_data}, 0);
    rst = 0;
    in_ctl = 0; in_data = 16'h1234;

    // R2 start after interval, R3 burst length for alpha=2
    cfg_interval = 8; cfg_alpha = 2;
    k = 0;
    while (!busy && k < 50) begin k++; step(); end
    chk(k == 9, "R2 start delay", k, 9);
    cnt = 0;
    while (busy && cnt < 200) begin cnt++; step(); end
    chk(cnt == 60, "R3 busy length", cnt, 60);

    // R2 gap low blocks training
    in_gap = 0;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin step(); if (busy) cnt++; end
    chk(cnt == 0, "R2 gap hold", cnt, 0);
    in_gap = 1;
    step();
    chk(busy == 1, "R2 start on gap", busy, 1);
    while (busy) step();

    // R4 force
    cfg_interval = 16'hFFFF; cfg_alpha = 0; cfg_force = 1;
    step();
    cnt = 0;
    for (int i = 0; i < 100; i++) begin step(); if (busy) cnt++; end
    chk(cnt == 100, "R4 continuous", cnt, 100);
    cfg_force = 0;
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; step(); end
    chk(cnt >= 1 && cnt <= 20, "R4 stop at boundary", cnt, 20);

    // R7 clear with count zero
    cfg_bit_delay = 0; in_ctl = 0;
    cfg_dip_num = 5; cmd_err_ins = 1; step();
    cmd_err_ins = 0;
    chk(err_pend == 1, "R6 arm", err_pend, 1);
    cfg_dip_num = 0; cmd_err_ins = 1; step();
    cmd_err_ins = 0;
    chk(err_pend == 0, "R7 zero clears", err_pend, 0);
    in_ctl = 1; in_data = 16'h00A5;
    step();
    chk(out_data == 16'h00A5, "R7 no corruption", out_data, 16'h00A5);

    // R6 corrupt exactly three control words, data words untouched
    in_ctl = 0; cfg_dip_num = 3; cmd_err_ins = 1; step();
    cmd_err_ins = 0;
    flips_seen = 0;
    for (int i = 0; i < 10; i++) begin
      in_ctl = (i % 2 == 0);
      in_data = 16'(16'h0500 + i);
      prev_in0 = int'(in_data[0]);
      step();
      if (int'(out_data[0]) != prev_in0) flips_seen++;
    end
    chk(flips_seen == 3, "R6 flip count", flips_seen, 3);
    chk(err_pend == 0, "R7 self clear", err_pend, 0);

    // R8 directed skew of 3
    cfg_bit_delay = 3; in_ctl = 0; in_data = 16'h0001; step();
    in_data = 16'h0000;
    for (int i = 0; i < 3; i++) step();
    chk(out_data[0] == 1, "R8 delay 3", out_data[0], 1);

    // random mix
    cfg_interval = 60;
    for (int i = 0; i < 4000; i++) begin
      in_data = 16'($urandom);
      in_ctl = ($urandom % 3) == 0;
      in_gap = ($urandom % 10) < 7;
      cmd_err_ins = ($urandom % 50) == 0;
      cfg_dip_num = 4'($urandom);
      if (($urandom % 100) == 0) cfg_bit_delay = 2'($urandom);
      if (($urandom % 200) == 0) cfg_alpha = 8'($urandom % 4);
      if (($urandom % 400) == 0) cfg_interval = 16'(40 + $urandom % 60);
      cfg_force = (i >= 2000 && i < 2100);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule